// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that a processor drives through three byte-wide registers: data, status and control. Transmit has two stages. A holding buffer takes the byte that software writes, and a shift register serialises it. When the shifter is idle, a written byte falls through to the shifter at once. This frees the holding buffer for the next byte, and consecutive bytes leave the block as one unbroken clock train. Every completed frame lands in a receive buffer. Status flags report when the holding buffer can take a byte, when a received byte is waiting, and when a received byte was lost.

The serial side runs in clock mode 0. SCLK idles low, data is sampled on the rising edge and changes on the falling edge, and bits go out most significant first. A programmable divider sets the SCLK rate. A control bit selects normal two-wire operation or a single-wire half-duplex mode. In single-wire mode the data pin is shared, and a direction bit decides whether the block drives the pin or leaves it to the far end. A frame always completes as a receive event, whichever way the pin is pointing. Software drives chip select through a general-purpose output bit in the control register.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the status register reads 0x20 (transmit-empty set, everything else clear). The control register reads 0x04. SCLK is low, `cs_out` is high and `mosi_oe` is high.
- R2: Register selects are 0 for data, 1 for status and 2 for control. A data write is accepted whenever the holding buffer is empty (status bit 5 set). When the shifter is idle, the byte moves to the shifter on the next clock and status bit 5 reads 1 again no later than two clocks after the write.
- R3: Two data writes on consecutive clocks with the shifter idle are both sent with no pause in SCLK. A data write made while the holding buffer is still full is ignored.
- R4: SCLK idles low. Its period is 2×(div+1) system clocks, where div is control bits [7:4]. MOSI changes only on falling edges and carries the byte MSB first.
- R5: At the end of every 8-bit frame, status bit 7 (receive-full) sets. The data register then returns the byte sampled MSB first on rising SCLK edges.
- R6: If a frame completes while receive-full is still set, status bit 6 (overrun) sets. The older byte stays in the data register and the new byte is discarded.
- R7: Receive-full and overrun clear only when software reads the status register while the flag is set and then reads the data register. A data read with no such status read leaves the flags set.
- R8: Control bit 0 selects single-wire mode and control bit 1 selects its direction. With bit 0 clear, `mosi_oe` is high and the block samples `miso_i`. With bit 0 set, `mosi_oe` equals bit 1 and the block samples `mosi_i`. In output direction a frame still sets receive-full and captures the level seen on the shared pin.
- R9: A control write made while busy updates bits [2:0] but leaves the divider unchanged. A control write made while idle updates the divider.
- R10: `cs_out` follows control bit 2.
- R11: Status bit 0 (busy) is high while a frame is in progress. It is low once the last bit has completed and SCLK is back low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 data, 1 status, 2 control |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe; triggers the flag-clear side effects |
| rd_data | output | 8 | Selected register value, combinational |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi_o | output | 1 | Serial data out; the shared pin in single-wire mode |
| mosi_oe | output | 1 | Drive enable for the data-out pin |
| mosi_i | input | 1 | Level on the data-out pin, sampled in single-wire mode |
| miso_i | input | 1 | Serial data in for two-wire mode |
| cs_out | output | 1 | General-purpose output used as chip select |

## Verification
The bench goes after the byte hand-off between holding buffer and shifter. A design that reloaded the shifter one clock late would stretch SCLK low between back-to-back bytes. A design that accepted writes into a full buffer would send a third byte or corrupt the second. For overrun, the bench checks that the first byte survives: a design that overwrote it would return the later response. For the flag clear, the bench checks that a bare data read leaves receive-full set. In single-wire mode, the bench feeds inverted data on `miso_i`, so a design that sampled the wrong pin returns the complement. It also sweeps the divider to catch off-by-one periods and changes the divider mid-frame to catch a frame that changed speed.

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
  parameter int DW    = 8,
  parameter int DIV_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          sclk,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  input  logic          miso_i,
  output logic          cs_out
);
  localparam int CNT_W = $clog2(DW);
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

  logic [DW-1:0]    hold_q, shreg_q, rxbuf_q;
  logic             hold_full_q, busy_q, sclk_q, samp_q;
  logic             rx_full_q, ovr_q, rx_arm_q, ovr_arm_q;
  logic [CNT_W-1:0] bit_q;
  logic [DIV_W-1:0] div_q, tick_q;
  logic             bidir_q, dir_out_q, cs_q;

  wire data_wr   = wr_en && reg_sel == SEL_DATA;
  wire ctrl_wr   = wr_en && reg_sel == SEL_CTRL;
  wire data_rd   = rd_en && reg_sel == SEL_DATA;
  wire stat_rd   = rd_en && reg_sel == SEL_STAT;
  wire half      = busy_q && tick_q == div_q;
  wire last_fall = half && sclk_q && bit_q == LAST_BIT;
  wire start     = hold_full_q && (!busy_q || last_fall);
  wire accept    = data_wr && (!hold_full_q || start);
  wire rx_in     = bidir_q ? mosi_i : miso_i;
  wire rx_clr    = data_rd && rx_arm_q;
  wire ovr_clr   = data_rd && ovr_arm_q;
  wire [DW-1:0] rx_word = {shreg_q[DW-2:0], samp_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else if (accept) begin
      hold_q      <= wr_data;
      hold_full_q <= 1'b1;
    end else if (start) begin
      hold_full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      samp_q  <= 1'b0;
      bit_q   <= '0;
      tick_q  <= '0;
    end else if (start) begin
      shreg_q <= hold_q;
      busy_q  <= 1'b1;
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      tick_q  <= '0;
    end else if (busy_q) begin
      if (half) begin
        tick_q <= '0;
        sclk_q <= ~sclk_q;
        if (!sclk_q) begin
          samp_q <= rx_in;
        end else begin
          shreg_q <= rx_word;
          bit_q   <= bit_q + CNT_W'(1);
          if (bit_q == LAST_BIT) busy_q <= 1'b0;
        end
      end else begin
        tick_q <= tick_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q   <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
      rx_arm_q  <= 1'b0;
      ovr_arm_q <= 1'b0;
    end else begin
      if (stat_rd) begin
        rx_arm_q  <= rx_full_q;
        ovr_arm_q <= ovr_q;
      end else if (data_rd) begin
        rx_arm_q  <= 1'b0;
        ovr_arm_q <= 1'b0;
      end
      if (rx_clr)  rx_full_q <= 1'b0;
      if (ovr_clr) ovr_q     <= 1'b0;
      if (last_fall) begin
        if (!rx_full_q || rx_clr) begin
          rxbuf_q   <= rx_word;
          rx_full_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidir_q   <= 1'b0;
      dir_out_q <= 1'b0;
      cs_q      <= 1'b1;
      div_q     <= '0;
    end else if (ctrl_wr) begin
      bidir_q   <= wr_data[0];
      dir_out_q <= wr_data[1];
      cs_q      <= wr_data[2];
      if (!busy_q) div_q <= wr_data[4 +: DIV_W];
    end
  end

  always_comb begin
    rd_data = '0;
    case (reg_sel)
      SEL_DATA: rd_data = rxbuf_q;
      SEL_STAT: begin
        rd_data[DW-1] = rx_full_q;
        rd_data[DW-2] = ovr_q;
        rd_data[DW-3] = ~hold_full_q;
        rd_data[0]    = busy_q;
      end
      SEL_CTRL: begin
        rd_data[0]         = bidir_q;
        rd_data[1]         = dir_out_q;
        rd_data[2]         = cs_q;
        rd_data[4 +: DIV_W] = div_q;
      end
      default: rd_data = '0;
    endcase
  end

  assign sclk    = sclk_q;
  assign mosi_o  = shreg_q[DW-1];
  assign mosi_oe = !bidir_q || dir_out_q;
  assign cs_out  = cs_q;
endmodule

// File: rtl/spi_dbuf_master_chk.sv
module spi_dbuf_master_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic             mosi_o,
  input logic             mosi_oe,
  input logic             busy,
  input logic             hold_full,
  input logic             rx_full,
  input logic             ovr,
  input logic             bidir,
  input logic [DIV_W-1:0] div
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sclk); // R11
  AST_MOSI_STABLE_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(mosi_o)); // R4
  AST_OVR_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n) ovr |-> rx_full); // R6
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(div)); // R9
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n) (!busy && hold_full) |=> busy); // R2
  AST_OE_TWO_WIRE: assert property (@(posedge clk) disable iff (!rst_n) !bidir |-> mosi_oe); // R8
endmodule

bind spi_dbuf_master spi_dbuf_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
  .busy(busy_q), .hold_full(hold_full_q), .rx_full(rx_full_q), .ovr(ovr_q),
  .bidir(bidir_q), .div(div_q)
);

// File: tb/spi_dbuf_master_tb.sv
`timescale 1ns/1ps
module spi_dbuf_master_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic sclk, mosi_o, mosi_oe, mosi_i, miso_i, cs_out;
  logic bidir_tb = 0;
  logic [15:0] slv_tx = 0, slv_rx = 0;
  int errors = 0, checks = 0, cyc = 0, last_rise = -1, rises = 0, gmin = 1000, gmax = 0;
  logic sclk_prev = 0, done = 0;

  always #5 clk = ~clk;

  spi_dbuf_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sclk(sclk), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .mosi_i(mosi_i), .miso_i(miso_i), .cs_out(cs_out));

  wire pin = mosi_oe ? mosi_o : slv_tx[15];
  assign mosi_i = pin;
  assign miso_i = bidir_tb ? ~slv_tx[15] : slv_tx[15];

  always @(posedge sclk) slv_rx <= {slv_rx[14:0], pin};
  always @(negedge sclk) slv_tx <= {slv_tx[14:0], 1'b0};

  always @(negedge clk) begin
    cyc <= cyc + 1;
    sclk_prev <= sclk;
    if (sclk && !sclk_prev) begin
      rises <= rises + 1;
      if (last_rise >= 0) begin
        if (cyc - last_rise < gmin) gmin <= cyc - last_rise;
        if (cyc - last_rise > gmax) gmax <= cyc - last_rise;
      end
      last_rise <= cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    @(posedge clk);
    rises = 0; gmin = 1000; gmax = 0; last_rise = -1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; rd_en = 1; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s; #1 d = rd_data;
  endtask

  task automatic wait_bytes(input int n, input int dv);
    repeat (16 * (dv + 1) * n + 6) @(negedge clk);
  endtask

  logic [7:0] v;
  byte unsigned pats[5] = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    peek(1, v); chk(v == 8'h20, "R1 status", v, 8'h20);
    peek(2, v); chk(v == 8'h04, "R1 control", v, 8'h04);
    chk(sclk == 0 && cs_out == 1 && mosi_oe == 1, "R1 pins", {sclk, cs_out, mosi_oe}, 3'b011);

    wr(2, 8'h00);
    chk(cs_out == 0, "R10 cs low", cs_out, 0);
    wr(2, 8'h04);
    chk(cs_out == 1, "R10 cs high", cs_out, 1);

    for (int dv = 0; dv < 4; dv++) begin
      wr(2, 8'(dv << 4));
      for (int i = 0; i < 5; i++) begin
        logic [7:0] p, r;
        p = pats[i]; r = p ^ 8'h5A;
        slv_tx = {r, 8'h00};
        mon_clear();
        wr(0, p);
        peek(1, v);
        @(negedge clk);
        peek(1, v); chk(v[5] == 1, "R2 tx empty within two clocks", v[5], 1);
        chk(v[0] == 1, "R11 busy during frame", v[0], 1);
        wait_bytes(1, dv);
        chk(slv_rx[7:0] == p, "R4 MOSI MSB first", slv_rx[7:0], p);
        chk(rises == 8 && gmin == 2*(dv+1) && gmax == 2*(dv+1), "R4 SCLK period", gmax, 2*(dv+1));
        peek(1, v); chk(v[0] == 0 && sclk == 0, "R11 busy clear after frame", v[0], 0);
        rd(1, v); chk(v[7] == 1, "R5 receive full", v[7], 1);
        rd(0, v); chk(v == r, "R5 received byte", v, r);
      end
    end

    // R3 back-to-back and R6 overrun, divider 1
    wr(2, 8'h10);
    slv_tx = 16'hC3E1;
    mon_clear();
    @(negedge clk); reg_sel = 0; wr_data = 8'h96; wr_en = 1;
    @(negedge clk); wr_data = 8'h4D;
    @(negedge clk); wr_en = 0;
    wait_bytes(2, 1);
    chk(slv_rx == 16'h964D, "R3 both bytes sent", slv_rx, 16'h964D);
    chk(rises == 16 && gmax == 4, "R3 no gap", gmax, 4);
    rd(1, v); chk(v[7:6] == 2'b11, "R6 overrun flag", v[7:6], 3);
    rd(0, v); chk(v == 8'hC3, "R6 older byte kept", v, 8'hC3);
    peek(1, v); chk(v[7:6] == 2'b00, "R7 flags cleared", v[7:6], 0);

    // R3 write while holding full ignored, divider 0
    wr(2, 8'h00);
    slv_tx = 16'h0000;
    mon_clear();
    @(negedge clk); reg_sel = 0; wr_data = 8'h11; wr_en = 1;
    @(negedge clk); wr_data = 8'h22;
    @(negedge clk); wr_data = 8'h33;
    @(negedge clk); wr_en = 0;
    wait_bytes(3, 0);
    chk(slv_rx == 16'h1122 && rises == 16, "R3 third write ignored", slv_rx, 16'h1122);
    rd(1, v); rd(0, v);

    // R7 bare data read does not clear
    slv_tx = 16'h7E00;
    wr(0, 8'h01);
    wait_bytes(1, 0);
    rd(0, v);
    peek(1, v); chk(v[7] == 1, "R7 bare data read keeps flag", v[7], 1);
    rd(1, v); rd(0, v);
    chk(v == 8'h7E, "R7 data value", v, 8'h7E);
    peek(1, v); chk(v[7] == 0, "R7 cleared after sequence", v[7], 0);

    // R8 single-wire output
    wr(2, 8'h03); bidir_tb = 1;
    chk(mosi_oe == 1, "R8 oe output", mosi_oe, 1);
    slv_tx = 16'h0000;
    wr(0, 8'hC6);
    wait_bytes(1, 0);
    chk(slv_rx[7:0] == 8'hC6, "R8 pin driven", slv_rx[7:0], 8'hC6);
    rd(1, v); chk(v[7] == 1, "R8 receive full in output mode", v[7], 1);
    rd(0, v); chk(v == 8'hC6, "R8 captured pin", v, 8'hC6);

    // R8 single-wire input
    wr(2, 8'h01);
    chk(mosi_oe == 0, "R8 oe input", mosi_oe, 0);
    slv_tx = 16'h6B00;
    wr(0, 8'h00);
    wait_bytes(1, 0);
    rd(1, v); rd(0, v); chk(v == 8'h6B, "R8 sampled shared pin", v, 8'h6B);
    wr(2, 8'h00); bidir_tb = 0;
    chk(mosi_oe == 1, "R8 oe two-wire", mosi_oe, 1);

    // R9 divider change while busy
    wr(2, 8'h10);
    mon_clear();
    wr(0, 8'h5A);
    repeat (3) @(negedge clk);
    wr(2, 8'h34);
    wait_bytes(1, 1);
    peek(2, v); chk(v == 8'h14, "R9 divider frozen while busy", v, 8'h14);
    chk(gmin == 4 && gmax == 4, "R9 period unchanged", gmax, 4);
    wr(2, 8'h34);
    peek(2, v); chk(v == 8'h34, "R9 divider updates when idle", v, 8'h34);
    rd(1, v); rd(0, v);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule